// File: doc/BRIEF.md
# Self-Programming Flash Command Controller

This block is the command register and sequencer that lets a small microcontroller reprogram its own program memory. Software first writes a command pattern into the register, which arms the controller. A store instruction must then follow within a short window. The store strobe carries a word address and a 16-bit data word. Depending on the armed pattern, the controller does one of three things:

- It writes the data word into one slot of the temporary page buffer.
- It starts a page erase or a page write on the flash array and halts the CPU until the array reports completion.
- It emits a one-cycle request for one of two auxiliary operations: lock-bit setting or re-enabling the read section.

An armed command that is not used before the window closes clears itself. A register write that does not form one of the accepted patterns is discarded. While an erase or write is running, the controller holds its command state, shows a busy flag and refuses new register writes.

Top module: `spm_cmd_ctrl`

## Requirements
- R1: A register write that is accepted arms the command. A store strobe sampled at any of the next four rising clock edges executes it. If no store arrives, the command bits read back as 0 after the fourth edge.
- R2: Only the command patterns 00001, 00011, 00101, 01001 and 10001 are accepted. Any other value, including 00000, leaves the register unchanged.
- R3: With 00011 armed, a store produces a one-cycle `erase_req` in the cycle after the store edge. `page_addr` then equals store address bits [15:6], and the data word plays no part.
- R4: With 00101 armed, a store produces a one-cycle `write_req` in the cycle after the store edge, with `page_addr` equal to store address bits [15:6].
- R5: With 00001 armed, a store produces a one-cycle `buf_we` together with `buf_word` = address bits [5:1] and `buf_data` = the data word. The command bits then read back as 0. Address bit 0 is not an input.
- R6: With 10001 armed, a store produces a one-cycle `rww_pulse`. With 01001 armed, a store produces a one-cycle `lock_pulse`. In both cases the command bits read back as 0 afterwards.
- R7: During an erase or write, read-back bit 6 is 1 and the armed pattern, including enable bit 0, stays visible. Both clear after the edge at which `flash_done` is sampled high.
- R8: `cpu_halt` is high from the store edge that starts an erase or write until the edge that samples `flash_done`, and it is low at all other times.
- R9: Register writes made during an erase or write have no effect. A store strobe with no armed command produces no output pulse.
- R10: Read-back layout: bits [4:0] hold the command pattern, bit 6 is busy, and bits 7 and 5 read 0. After reset, read-back is 0 and every request output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Command register write strobe |
| reg_wdata | input | 5 | Command pattern to write |
| reg_rdata | output | 8 | Register read-back |
| st_valid | input | 1 | Store instruction issued |
| st_zaddr | input | 15 | Store address bits [15:1] |
| st_data | input | 16 | Store data word |
| flash_done | input | 1 | One-cycle completion from flash array |
| buf_we | output | 1 | Page buffer write pulse |
| buf_word | output | 5 | Page buffer word index |
| buf_data | output | 16 | Page buffer write data |
| erase_req | output | 1 | Page erase request pulse |
| write_req | output | 1 | Page write request pulse |
| page_addr | output | 10 | Page address for erase/write |
| lock_pulse | output | 1 | Lock-bit set request pulse |
| rww_pulse | output | 1 | Read-section re-enable pulse |
| cpu_halt | output | 1 | CPU halt during erase/write |

## Verification
The bench issues stores both at the last edge of the window and one edge after it closes. A window that is one cycle short, or one cycle long, either drops a legal store or executes a stale one. It writes illegal patterns, including all-zero and all-ones, and checks they are discarded; a decoder keyed on single bits would accept them. During a running erase it tries both a register write and a store, and checks for leaked pulses or changed state. It also holds the halt signal over several cycles before completion, which catches a halt driven by the request pulse instead of by the busy state.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int CMD_W   = 5;
  localparam int B_EN    = 0;
  localparam int B_ERASE = 1;
  localparam int B_WRITE = 2;
  localparam int B_LOCK  = 3;
  localparam int B_RWW   = 4;
  localparam int B_BUSY  = 6;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_FILL  = 3'd1,
    OP_ERASE = 3'd2,
    OP_WRITE = 3'd3,
    OP_LOCK  = 3'd4,
    OP_RWW   = 3'd5
  } spm_op_e;
endpackage

// File: rtl/spm_cmd_decode.sv
module spm_cmd_decode
  import spm_pkg::*;
(
  input  logic [CMD_W-1:0] pat,
  output logic             legal,
  output spm_op_e          op
);
  always_comb begin
    legal = 1'b1;
    op    = OP_NONE;
    unique case (pat)
      5'b00001: op = OP_FILL;
      5'b00011: op = OP_ERASE;
      5'b00101: op = OP_WRITE;
      5'b01001: op = OP_LOCK;
      5'b10001: op = OP_RWW;
      default:  legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/spm_arm_window.sv
module spm_arm_window #(
  parameter int WIN_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clear,
  output logic armed,
  output logic expire
);
  localparam int CNT_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYC - 1);

  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (load) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (clear) begin
      armed_d = 1'b0;
    end else if (armed_q) begin
      if (cnt_q == LAST) armed_d = 1'b0;
      else               cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  assign armed  = armed_q;
  assign expire = armed_q && (cnt_q == LAST);

  p_win_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (armed_q && cnt_q == '0));
  p_win_close_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load && !clear) |=> !armed_q);
endmodule

// File: rtl/spm_op_seq.sv
module spm_op_seq
  import spm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int WORD_W = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_we,
  input  logic [CMD_W-1:0]          reg_wdata,
  input  logic                      wr_legal,
  input  spm_op_e                   cur_op,
  input  logic                      armed,
  input  logic                      expire,
  input  logic                      st_valid,
  input  logic [ADDR_W-1:1]         st_zaddr,
  input  logic [DATA_W-1:0]         st_data,
  input  logic                      flash_done,
  output logic                      fire,
  output logic                      accept_wr,
  output logic [CMD_W-1:0]          cmd,
  output logic                      busy,
  output logic                      buf_we,
  output logic [WORD_W-1:0]         buf_word,
  output logic [DATA_W-1:0]         buf_data,
  output logic                      erase_req,
  output logic                      write_req,
  output logic [ADDR_W-WORD_W-2:0]  page_addr,
  output logic                      lock_pulse,
  output logic                      rww_pulse
);
  localparam int PAGE_W = ADDR_W - WORD_W - 1;

  typedef enum logic {S_IDLE = 1'b0, S_BUSY = 1'b1} seq_st_e;

  seq_st_e             st_q, st_d;
  logic [CMD_W-1:0]    cmd_q, cmd_d;
  logic [PAGE_W-1:0]   page_q;
  logic [WORD_W-1:0]   word_q;
  logic [DATA_W-1:0]   data_q;
  logic                fill_q, fill_d, er_q, er_d, wr_q, wr_d, lk_q, lk_d, rw_q, rw_d;
  logic                cap_en;

  always_comb begin
    st_d      = st_q;
    cmd_d     = cmd_q;
    fill_d    = 1'b0;
    er_d      = 1'b0;
    wr_d      = 1'b0;
    lk_d      = 1'b0;
    rw_d      = 1'b0;
    accept_wr = 1'b0;
    fire      = st_valid && armed && (st_q == S_IDLE);
    unique case (st_q)
      S_IDLE: begin
        if (fire) begin
          unique case (cur_op)
            OP_FILL:  begin fill_d = 1'b1; cmd_d = '0; end
            OP_ERASE: begin er_d = 1'b1; st_d = S_BUSY; end
            OP_WRITE: begin wr_d = 1'b1; st_d = S_BUSY; end
            OP_LOCK:  begin lk_d = 1'b1; cmd_d = '0; end
            OP_RWW:   begin rw_d = 1'b1; cmd_d = '0; end
            default:  cmd_d = '0;
          endcase
        end else if (reg_we && wr_legal) begin
          accept_wr = 1'b1;
          cmd_d     = reg_wdata;
        end else if (expire) begin
          cmd_d = '0;
        end
      end
      S_BUSY: begin
        if (flash_done) begin
          st_d  = S_IDLE;
          cmd_d = '0;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  assign cap_en = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cmd_q  <= '0;
      fill_q <= 1'b0;
      er_q   <= 1'b0;
      wr_q   <= 1'b0;
      lk_q   <= 1'b0;
      rw_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cmd_q  <= cmd_d;
      fill_q <= fill_d;
      er_q   <= er_d;
      wr_q   <= wr_d;
      lk_q   <= lk_d;
      rw_q   <= rw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      word_q <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      page_q <= st_zaddr[ADDR_W-1:WORD_W+1];
      word_q <= st_zaddr[WORD_W:1];
      data_q <= st_data;
    end
  end

  assign cmd        = cmd_q;
  assign busy       = (st_q == S_BUSY);
  assign buf_we     = fill_q;
  assign buf_word   = word_q;
  assign buf_data   = data_q;
  assign erase_req  = er_q;
  assign write_req  = wr_q;
  assign page_addr  = page_q;
  assign lock_pulse = lk_q;
  assign rww_pulse  = rw_q;

  p_one_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fill_q, er_q, wr_q, lk_q, rw_q}));
  p_req_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (er_q || wr_q) |-> (st_q == S_BUSY));
  p_en_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_BUSY) |-> (cmd_q[B_EN] && (cmd_q[B_ERASE] ^ cmd_q[B_WRITE])));
  p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_BUSY && flash_done) |=> (cmd_q == '0 && st_q == S_IDLE));
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_BUSY && !flash_done) |=> ($stable(cmd_q) && $stable(page_q)));
  p_no_arm_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !armed) |=> !(fill_q || er_q || wr_q || lk_q || rw_q));
endmodule

// File: rtl/spm_cmd_ctrl.sv
module spm_cmd_ctrl
  import spm_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 32,
  parameter int WIN_CYC    = 4,
  parameter int REG_W      = 8
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      reg_we,
  input  logic [CMD_W-1:0]                          reg_wdata,
  output logic [REG_W-1:0]                          reg_rdata,
  input  logic                                      st_valid,
  input  logic [ADDR_W-1:1]                         st_zaddr,
  input  logic [DATA_W-1:0]                         st_data,
  input  logic                                      flash_done,
  output logic                                      buf_we,
  output logic [$clog2(PAGE_WORDS)-1:0]             buf_word,
  output logic [DATA_W-1:0]                         buf_data,
  output logic                                      erase_req,
  output logic                                      write_req,
  output logic [ADDR_W-$clog2(PAGE_WORDS)-2:0]      page_addr,
  output logic                                      lock_pulse,
  output logic                                      rww_pulse,
  output logic                                      cpu_halt
);
  localparam int WORD_W = $clog2(PAGE_WORDS);

  logic             wr_legal, cur_legal, armed, expire, fire, accept_wr, busy;
  spm_op_e          wr_op, cur_op;
  logic [CMD_W-1:0] cmd;

  spm_cmd_decode u_dec_wr (.pat(reg_wdata), .legal(wr_legal),  .op(wr_op));
  spm_cmd_decode u_dec_cur(.pat(cmd),       .legal(cur_legal), .op(cur_op));

  spm_arm_window #(.WIN_CYC(WIN_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .load(accept_wr), .clear(fire),
    .armed(armed), .expire(expire)
  );

  spm_op_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .wr_legal(wr_legal), .cur_op(cur_op), .armed(armed), .expire(expire),
    .st_valid(st_valid), .st_zaddr(st_zaddr), .st_data(st_data),
    .flash_done(flash_done), .fire(fire), .accept_wr(accept_wr),
    .cmd(cmd), .busy(busy), .buf_we(buf_we), .buf_word(buf_word),
    .buf_data(buf_data), .erase_req(erase_req), .write_req(write_req),
    .page_addr(page_addr), .lock_pulse(lock_pulse), .rww_pulse(rww_pulse)
  );

  always_comb begin
    reg_rdata              = '0;
    reg_rdata[CMD_W-1:0]   = cmd;
    reg_rdata[B_BUSY]      = busy;
  end

  assign cpu_halt = busy;

  p_arm_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (cur_legal && cur_op != OP_NONE));
  p_wr_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_wr |-> (wr_legal && wr_op != OP_NONE));
  p_halt_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req || write_req) |-> cpu_halt);
endmodule

// File: tb/sim_spm_cmd_ctrl.sv
module sim_spm_cmd_ctrl;
  logic        clk, rst_n;
  logic        reg_we, st_valid, flash_done;
  logic [4:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [15:1] st_zaddr;
  logic [15:0] st_data, buf_data;
  logic [4:0]  buf_word;
  logic [9:0]  page_addr;
  logic        buf_we, erase_req, write_req, lock_pulse, rww_pulse, cpu_halt;

  int n_tests, n_fail;
  bit finished;

  spm_cmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .st_valid(st_valid), .st_zaddr(st_zaddr),
    .st_data(st_data), .flash_done(flash_done), .buf_we(buf_we),
    .buf_word(buf_word), .buf_data(buf_data), .erase_req(erase_req),
    .write_req(write_req), .page_addr(page_addr), .lock_pulse(lock_pulse),
    .rww_pulse(rww_pulse), .cpu_halt(cpu_halt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // vector: pat[42:38] delay[37:35] z[34:19] data[18:3] op[2:0]
  // op: 0 none, 1 fill, 2 erase, 3 write, 4 lock, 5 rww
  localparam int NV = 10;
  localparam logic [42:0] VEC [NV] = '{
    {5'b00001, 3'd0, 16'h00A7, 16'h1234, 3'd1},
    {5'b00001, 3'd3, 16'h003F, 16'hBEEF, 3'd1},
    {5'b00011, 3'd1, 16'hABC0, 16'hFFFF, 3'd2},
    {5'b00101, 3'd2, 16'h1240, 16'h0000, 3'd3},
    {5'b01001, 3'd0, 16'h0000, 16'h0000, 3'd4},
    {5'b10001, 3'd3, 16'h0000, 16'h0000, 3'd5},
    {5'b00001, 3'd4, 16'h0010, 16'h5555, 3'd0},
    {5'b00111, 3'd0, 16'h0010, 16'h5555, 3'd0},
    {5'b00000, 3'd0, 16'h0010, 16'h5555, 3'd0},
    {5'b11111, 3'd1, 16'h0010, 16'h5555, 3'd0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] pulses();
    return {buf_we, erase_req, write_req, lock_pulse, rww_pulse};
  endfunction

  function automatic logic [4:0] exp_pulse(input int op);
    case (op)
      1: return 5'b10000;
      2: return 5'b01000;
      3: return 5'b00100;
      4: return 5'b00010;
      5: return 5'b00001;
      default: return 5'b00000;
    endcase
  endfunction

  task automatic wr_reg(input logic [4:0] v);
    reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic store(input logic [15:0] z, input logic [15:0] d);
    st_valid = 1'b1; st_zaddr = z[15:1]; st_data = d;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic done_pulse();
    flash_done = 1'b1;
    @(negedge clk);
    flash_done = 1'b0;
  endtask

  initial begin
    n_tests = 0; n_fail = 0; finished = 0;
    reg_we = 0; reg_wdata = '0; st_valid = 0; st_zaddr = '0; st_data = '0; flash_done = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reg_rdata == 8'h00, "R10 reset readback", reg_rdata, 0);
    chk(pulses() == 0 && !cpu_halt, "R10 reset outputs", {pulses(), cpu_halt}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [4:0]  pat;
      int          dly, op;
      logic [15:0] z, d;
      bit          legal;
      pat = VEC[i][42:38]; dly = int'(VEC[i][37:35]); z = VEC[i][34:19];
      d = VEC[i][18:3]; op = int'(VEC[i][2:0]);
      legal = (pat == 5'b00001 || pat == 5'b00011 || pat == 5'b00101 ||
               pat == 5'b01001 || pat == 5'b10001);
      wr_reg(pat);
      chk(reg_rdata == (legal ? {3'b000, pat} : 8'h00), "R2 pattern accept/reject", reg_rdata, legal ? pat : 0);
      for (int k = 0; k < dly; k++) @(negedge clk);
      if (legal && dly >= 4)
        chk(reg_rdata == 8'h00, "R1 window expiry clears bits", reg_rdata, 0);
      store(z, d);
      chk(pulses() == exp_pulse(op), "R3 R4 R5 R6 R1 command pulse", pulses(), exp_pulse(op));
      if (op == 1) begin
        chk(buf_word == z[5:1] && buf_data == d, "R5 fill word/data", {buf_word, buf_data}, {z[5:1], d});
        chk(reg_rdata == 8'h00, "R5 bits clear after fill", reg_rdata, 0);
      end
      if (op == 4 || op == 5)
        chk(reg_rdata == 8'h00, "R6 bits clear after special", reg_rdata, 0);
      if (op == 2 || op == 3) begin
        chk(page_addr == z[15:6], "R3 R4 page address", page_addr, z[15:6]);
        chk(reg_rdata == {3'b010, pat}, "R7 busy readback", reg_rdata, {3'b010, pat});
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk(cpu_halt && pulses() == 0, "R8 halt held, no repeat pulse", {cpu_halt, pulses()}, 6'b100000);
        end
        chk(reg_rdata == {3'b010, pat}, "R7 enable held while busy", reg_rdata, {3'b010, pat});
        done_pulse();
        chk(reg_rdata == 8'h00 && !cpu_halt, "R7 R8 cleared after done", {cpu_halt, reg_rdata}, 0);
      end
      if (op == 0)
        chk(reg_rdata == 8'h00, "R9 unarmed store leaves state", reg_rdata, 0);
      @(negedge clk);
    end

    // R9: writes and stores during erase are ignored
    wr_reg(5'b00011);
    store(16'hFFC0, 16'h0);
    chk(erase_req && cpu_halt, "R3 erase starts", {erase_req, cpu_halt}, 2'b11);
    wr_reg(5'b00001);
    chk(reg_rdata == 8'h43, "R9 write ignored while busy", reg_rdata, 8'h43);
    store(16'h0002, 16'hAAAA);
    chk(pulses() == 0 && page_addr == 10'h3FF, "R9 store ignored while busy", {pulses(), page_addr}, 15'h3FF);
    done_pulse();
    chk(!cpu_halt && reg_rdata == 8'h00, "R8 halt drops after done", {cpu_halt, reg_rdata}, 0);

    // R9: store with nothing armed
    store(16'h0004, 16'h7777);
    chk(pulses() == 0, "R9 store without arm", pulses(), 0);

    // R1: store on the last window edge works; re-arm restarts window
    wr_reg(5'b00001);
    repeat (2) @(negedge clk);
    wr_reg(5'b10001);
    repeat (2) @(negedge clk);
    chk(reg_rdata == 8'h11, "R1 rearm restarts window", reg_rdata, 8'h11);
    @(negedge clk);
    store(16'h0, 16'h0);
    chk(rww_pulse, "R6 R1 rww on last window edge", rww_pulse, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule